// File: doc/BRIEF.md
# Machine Security Configuration Register

This block holds the machine-level security configuration word that steers the memory protection checker. It keeps three control flags: a lockdown flag that switches the checker into its strict rule set, a deny-by-default flag that refuses machine accesses which match no rule, and a bypass flag that lets firmware rewrite locked protection entries while the system boots. Software writes the word through a single-cycle write strobe. The current value is read back combinationally, and the three flags go directly to the protection logic.

The two policy flags can only be set. Once written to one, each stays at one until reset. The bypass flag takes whatever value is written, with one exception: if any protection entry is locked and the bypass flag is already clear, the flag stays clear. This stops software from reopening locked entries after boot.

The block is told how many protection entries exist and whether any of them carries a lock bit. When no entries exist, writes are dropped. Every accepted write raises a flush pulse for one cycle, so that cached address translations are discarded and rebuilt under the new policy.

Top module: `seccfg_reg`

## Requirements
- R1: After reset the readback word is zero, all three flag outputs are low and `tlb_flush` is low.
- R2: A write while `num_entries` is zero changes nothing: the readback word keeps its value and `tlb_flush` stays low.
- R3: The lockdown flag (readback bit 0, output `lockdown`) is set by an accepted write with data bit 0 high. Later writes cannot clear it; only reset can.
- R4: The deny-by-default flag (readback bit 1, output `deny_default`) is set by an accepted write with data bit 1 high. Later writes cannot clear it; only reset can.
- R5: Unless R6 applies, an accepted write copies data bit 2 into the bypass flag (readback bit 2, output `lock_bypass`). This includes clearing it while `any_entry_locked` is high.
- R6: When `any_entry_locked` is high and the bypass flag is currently zero, an accepted write leaves the bypass flag at zero.
- R7: `tlb_flush` is high in the cycle after each accepted write and low otherwise. Back-to-back accepted writes keep it high without a gap.
- R8: Readback bits above bit 2 always read as zero, whatever data was written.
- R9: The three flag outputs always equal readback bits 0, 1 and 2, and a write takes effect on the clock edge at which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | DATA_W | Write data; bits 0..2 are used |
| any_entry_locked | input | 1 | OR of the lock bits of all protection entries, disabled ones included |
| num_entries | input | CNT_W | Number of implemented protection entries |
| rd_data | output | DATA_W | Combinational readback of the register |
| lockdown | output | 1 | Strict-rule lockdown flag |
| deny_default | output | 1 | Deny accesses that match no rule |
| lock_bypass | output | 1 | Locked-entry rewrite bypass |
| tlb_flush | output | 1 | One-cycle translation flush pulse |

## Verification
The bench uses the defaults: a 32-bit data word and a 5-bit entry count. The wide word allows writes of all ones and of upper-bits-only patterns, which shows that only the three low bits are kept. The count width lets the bench drive both a zero count, where writes must be dropped, and a nonzero count of four. With both counts reachable, together with both levels of the lock summary, the bench can walk the bypass flag through its set, clear and frozen cases.

// File: rtl/seccfg_pkg.sv
package seccfg_pkg;

    localparam int unsigned CFG_W         = 3;
    localparam int unsigned LOCKDOWN_BIT  = 0;
    localparam int unsigned DENY_BIT      = 1;
    localparam int unsigned BYPASS_BIT    = 2;

    // Packed so that bypass lands in bit 2 and lockdown in bit 0.
    typedef struct packed {
        logic bypass;
        logic deny;
        logic lockdown;
    } cfg_bits_t;

    typedef struct packed {
        cfg_bits_t bits;
        logic      flush;
    } seccfg_state_t;

endpackage

// File: rtl/seccfg_sticky.sv
// Set-only flags: a bit rises on an accepted write with a one, never falls.
module seccfg_sticky #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             set_en,
    input  logic [WIDTH-1:0] set_val,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign nxt[i] = cur[i] | (set_en & set_val[i]);
    end
endmodule

// File: rtl/seccfg_bypass_gate.sv
// Bypass flag update: follows the write unless frozen at zero by a lock.
module seccfg_bypass_gate (
    input  logic wr_accept,
    input  logic wr_val,
    input  logic cur,
    input  logic any_lock,
    output logic nxt
);
    logic frozen;

    always_comb begin
        frozen = any_lock & ~cur;
        nxt    = (wr_accept && !frozen) ? wr_val : cur;
    end
endmodule

// File: rtl/seccfg_reg.sv
module seccfg_reg
    import seccfg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              any_entry_locked,
    input  logic [CNT_W-1:0]  num_entries,
    output logic [DATA_W-1:0] rd_data,
    output logic              lockdown,
    output logic              deny_default,
    output logic              lock_bypass,
    output logic              tlb_flush
);
    localparam int unsigned PAD_W = DATA_W - CFG_W;

    seccfg_state_t state_d, state_q;
    logic          wr_accept;
    logic [1:0]    sticky_cur, sticky_nxt;
    logic          bypass_nxt;
    logic          unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

    assign wr_accept  = wr_en && (num_entries != '0);
    assign sticky_cur = {state_q.bits.deny, state_q.bits.lockdown};

    seccfg_sticky #(.WIDTH(2)) u_sticky (
        .set_en  (wr_accept),
        .set_val ({wr_data[DENY_BIT], wr_data[LOCKDOWN_BIT]}),
        .cur     (sticky_cur),
        .nxt     (sticky_nxt)
    );

    seccfg_bypass_gate u_bypass (
        .wr_accept (wr_accept),
        .wr_val    (wr_data[BYPASS_BIT]),
        .cur       (state_q.bits.bypass),
        .any_lock  (any_entry_locked),
        .nxt       (bypass_nxt)
    );

    always_comb begin
        state_d               = state_q;
        state_d.bits.lockdown = sticky_nxt[0];
        state_d.bits.deny     = sticky_nxt[1];
        state_d.bits.bypass   = bypass_nxt;
        state_d.flush         = wr_accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data      = {{PAD_W{1'b0}}, state_q.bits};
    assign lockdown     = state_q.bits.lockdown;
    assign deny_default = state_q.bits.deny;
    assign lock_bypass  = state_q.bits.bypass;
    assign tlb_flush    = state_q.flush;

    // R2: dropped writes leave the word alone and raise no flush
    a_r2_no_entries_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && num_entries == '0) |=> ($stable(rd_data) && !tlb_flush));

    // R3: lockdown never falls while out of reset
    a_r3_lockdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lockdown |=> lockdown);

    // R4: deny-by-default never falls while out of reset
    a_r4_deny_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        deny_default |=> deny_default);

    // R6: a lock present with bypass clear keeps bypass clear
    a_r6_bypass_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (any_entry_locked && !lock_bypass) |=> !lock_bypass);

    // R7: every accepted write yields a flush in the next cycle
    a_r7_flush_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && num_entries != '0) |=> tlb_flush);

    // R7: no flush without a preceding accepted write
    a_r7_flush_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && num_entries != '0) |=> !tlb_flush);

endmodule

// File: tb/seccfg_reg_tb.sv
module seccfg_reg_tb;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = 5;

    typedef struct {
        logic [DATA_W-1:0] rd;
        logic              fl;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              any_entry_locked = 1'b0;
    logic [CNT_W-1:0]  num_entries = '0;
    logic [DATA_W-1:0] rd_data;
    logic              lockdown, deny_default, lock_bypass, tlb_flush;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    exp_t q[$];

    logic m_ld = 1'b0, m_dn = 1'b0, m_bp = 1'b0;

    always #4 clk = ~clk;

    seccfg_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk, .rst_n, .wr_en, .wr_data, .any_entry_locked, .num_entries,
        .rd_data, .lockdown, .deny_default, .lock_bypass, .tlb_flush
    );

    function automatic logic [DATA_W-1:0] model_word();
        return {{(DATA_W-3){1'b0}}, m_bp, m_dn, m_ld};
    endfunction

    task automatic compare(exp_t e);
        checks++;
        if (rd_data !== e.rd) begin
            errors++;
            $display("FAIL %s rd_data got %h exp %h", e.tag, rd_data, e.rd);
        end
        checks++;
        if (tlb_flush !== e.fl) begin
            errors++;
            $display("FAIL %s tlb_flush got %b exp %b", e.tag, tlb_flush, e.fl);
        end
        checks++;  // R9: flags mirror readback bits
        if ({lock_bypass, deny_default, lockdown} !== e.rd[2:0]) begin
            errors++;
            $display("FAIL R9 (%s) flags got %b exp %b", e.tag,
                     {lock_bypass, deny_default, lockdown}, e.rd[2:0]);
        end
    endtask

    // Driver: one cycle of stimulus, expected result pushed after the edge.
    task automatic step(input logic we, input logic [DATA_W-1:0] d,
                        input logic [CNT_W-1:0] n, input logic lk, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        wr_en = we; wr_data = d; num_entries = n; any_entry_locked = lk;
        acc = we && (n != '0);
        if (acc) begin
            m_ld = m_ld | d[0];
            m_dn = m_dn | d[1];
            if (!(lk && !m_bp)) m_bp = d[2];
        end
        @(posedge clk);
        #2;
        e.rd = model_word(); e.fl = acc; e.tag = tag;
        q.push_back(e);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_ld = 1'b0; m_dn = 1'b0; m_bp = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops expectations between edges
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (2) @(negedge clk);
        r.rd = '0; r.fl = 1'b0; r.tag = "R1 reset";
        compare(r);
        rst_n = 1'b1;
        step(1'b1, 32'h7, 5'd0, 1'b0, "R2 no entries");
        step(1'b0, 32'h0, 5'd4, 1'b0, "R7 idle");
        step(1'b1, 32'h4, 5'd4, 1'b0, "R5 set bypass");
        step(1'b1, 32'h0, 5'd4, 1'b1, "R5 clear bypass under lock");
        step(1'b1, 32'h4, 5'd4, 1'b1, "R6 frozen bypass");
        step(1'b0, 32'h0, 5'd4, 1'b1, "R7 idle");
        step(1'b1, 32'h4, 5'd4, 1'b0, "R5 set bypass without lock");
        step(1'b1, 32'h1, 5'd4, 1'b0, "R3 set lockdown");
        step(1'b1, 32'h0, 5'd4, 1'b0, "R3 lockdown sticky");
        step(1'b0, 32'h0, 5'd4, 1'b0, "R7 pulse ends");
        step(1'b1, 32'h2, 5'd4, 1'b0, "R4 set deny");
        step(1'b1, 32'h0, 5'd4, 1'b0, "R4 deny sticky");
        step(1'b1, 32'hFFFF_FFF8, 5'd4, 1'b0, "R8 upper bits only");
        step(1'b1, 32'hFFFF_FFFF, 5'd4, 1'b0, "R8 all ones");
        step(1'b1, 32'h0, 5'd0, 1'b1, "R2 no entries after set");
        do_reset();
        @(negedge clk);
        r.rd = '0; r.fl = 1'b0; r.tag = "R1 R3 R4 cleared by reset";
        compare(r);
        step(1'b1, 32'h4, 5'd4, 1'b1, "R6 frozen after reset");
        step(1'b0, 32'h0, 5'd4, 1'b0, "R7 idle");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule